// File: doc/BRIEF.md
# Count-Line Polling Bus Arbiter

This block sits on the channel side of a shared bus and decides which of several devices may use it. It does not look at a vector of requests. Instead, every device drives one shared request line. When that line is active and the bus is idle, the channel starts a polling round. In each clock it broadcasts a device number on a small encoded count bus. Each device compares the count with its own fixed address, which runs from 1 to N_DEV. The first requesting device that sees its own number drives the shared busy line. The channel then stops counting, and that device holds the bus for as long as it keeps requesting.

A mode input sets where the next round starts after the owner lets go. In priority mode every round starts at device 1, so lower addresses always win. In round-robin mode a round starts at the device after the last owner, wrapping from N_DEV back to 1. The logic each device uses to match the count is part of the block. The data carried on the bus is not. A registered owner number shows which device holds the bus, with 0 meaning none.

Top module: `poll_arbiter`

## Requirements
- R1: `bus_req` is high exactly when at least one bit of `dev_req` is high. Bit i of `dev_req` belongs to the device with address i+1.
- R2: While no round is in progress, `poll_cnt` is 0. Count value 0 matches no device, so `bus_busy` stays low even when every device requests. A round starts only from idle, on a clock edge where `bus_req` is high and `bus_busy` is low.
- R3: During a round with no match, `poll_cnt` goes up by one on every clock, stays within 1..N_DEV, and wraps from N_DEV back to 1.
- R4: A device drives its `dev_busy` bit when it is requesting and `poll_cnt` equals its address. `bus_busy` is the OR of all `dev_busy` bits, and at most one bit is ever high. While `bus_busy` is high, `poll_cnt` does not change, and requests from other devices do not change the owner.
- R5: `owner_id` is registered. One clock after `bus_busy` is seen high, it equals the value `poll_cnt` had in that cycle. At other times it is 0.
- R6: With `rr_mode` = 0 (priority), every round starts with count 1. The owner is the lowest-addressed requester, and the latency from request to `owner_id` is 2 + (address - 1) clocks.
- R7: With `rr_mode` = 1 (round-robin), a round starts at the address after the last owner, with N_DEV followed by 1. After reset the last owner counts as 0, so the first round starts at 1.
- R8: If N_DEV counts pass in a round with no match, the arbiter returns to idle with `poll_cnt` = 0 on the next clock, and then samples the request line again.
- R9: When the owner drops its request, `bus_busy` falls. On the next clock `poll_cnt` and `owner_id` both return to 0.
- R10: During and just after reset, `poll_cnt`, `owner_id` and `bus_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_mode | input | 1 | 0 = each round starts at 1; 1 = each round starts after the last owner |
| dev_req | input | N_DEV | Request from each device; bit i belongs to address i+1 |
| bus_req | output | 1 | Shared request line (OR of all requests) |
| bus_busy | output | 1 | Shared busy line, driven by the matching device |
| dev_busy | output | N_DEV | Busy drive of each device |
| poll_cnt | output | CNT_W | Count broadcast on the count lines; 0 when not polling |
| owner_id | output | CNT_W | Registered number of the owning device; 0 when none |

## Verification
A wrong internal state always reaches the ports within one round.

A wrong restart point or a wrong wrap shows within N_DEV+2 clocks of a request. It appears as the wrong `owner_id`, or as a latency that differs from the distance from the start count to the winner.

A broken freeze changes `poll_cnt` while `bus_busy` is high, one clock later. A lost end-of-sweep check leaves `poll_cnt` non-zero on the clock after the N_DEV-th count.

A stale owner register shows as a non-zero `owner_id` one clock after release.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

   typedef enum logic [1:0] {
      PA_IDLE = 2'd0,
      PA_POLL = 2'd1,
      PA_HOLD = 2'd2
   } pa_state_e;

endpackage

// File: rtl/poll_dev_match.sv
// Device-side comparator: drives busy while requesting and addressed.
module poll_dev_match #(
   parameter int CNT_W = 3,
   parameter int ADDR  = 1
) (
   input  logic             req,
   input  logic [CNT_W-1:0] cnt,
   output logic             busy
);
   localparam logic [CNT_W-1:0] MY_ADDR = CNT_W'(ADDR);

   initial begin
      if (ADDR < 1 || ADDR >= (1 << CNT_W))
         $error("poll_dev_match: ADDR %0d outside 1..%0d", ADDR, (1 << CNT_W) - 1);
   end

   always_comb begin
      busy = req && (cnt == MY_ADDR);
   end
endmodule

// File: rtl/poll_restart.sv
// Selects the first count of a polling round from the mode and last owner.
module poll_restart #(
   parameter int N_DEV = 6,
   parameter int CNT_W = 3
) (
   input  logic             rr_mode,
   input  logic [CNT_W-1:0] last_owner,
   output logic [CNT_W-1:0] start_cnt
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(N_DEV);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] after_last;

   generate
      if ((1 << CNT_W) == N_DEV + 1) begin : g_full_code
         // All non-zero codes are device numbers: natural overflow hits 0.
         always_comb begin
            after_last = last_owner + ONE;
            if (after_last == '0) after_last = ONE;
         end
      end else begin : g_part_code
         always_comb begin
            if (last_owner >= TOP) after_last = ONE;
            else                   after_last = last_owner + ONE;
         end
      end
   endgenerate

   always_comb begin
      start_cnt = rr_mode ? after_last : ONE;
   end
endmodule

// File: rtl/poll_sequencer.sv
// Channel-side state machine that steps, freezes and clears the count.
module poll_sequencer
   import poll_arb_pkg::*;
#(
   parameter int N_DEV = 6,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_req,
   input  logic             bus_busy,
   input  logic [CNT_W-1:0] start_cnt,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] last_owner
);
   localparam logic [CNT_W-1:0] TOP = CNT_W'(N_DEV);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   pa_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] sweep_q;
   logic [CNT_W-1:0] last_q;

   function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c);
      return (c >= TOP) ? ONE : c + ONE;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PA_IDLE;
         cnt_q   <= '0;
         sweep_q <= '0;
         last_q  <= '0;
      end else begin
         case (st_q)
            PA_IDLE: begin
               if (bus_req && !bus_busy) begin
                  st_q    <= PA_POLL;
                  cnt_q   <= start_cnt;
                  sweep_q <= ONE;
               end
            end
            PA_POLL: begin
               if (bus_busy) begin
                  st_q <= PA_HOLD;
               end else if (sweep_q == TOP) begin
                  st_q    <= PA_IDLE;
                  cnt_q   <= '0;
                  sweep_q <= '0;
               end else begin
                  cnt_q   <= step_cnt(cnt_q);
                  sweep_q <= sweep_q + ONE;
               end
            end
            PA_HOLD: begin
               if (!bus_busy) begin
                  st_q    <= PA_IDLE;
                  last_q  <= cnt_q;
                  cnt_q   <= '0;
                  sweep_q <= '0;
               end
            end
            default: begin
               st_q    <= PA_IDLE;
               cnt_q   <= '0;
               sweep_q <= '0;
            end
         endcase
      end
   end

   assign cnt        = cnt_q;
   assign last_owner = last_q;

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PA_IDLE) |-> (cnt_q == '0)) else $error("idle count non-zero"); // R2

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= TOP)) else $error("count out of range"); // R3

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PA_POLL && !bus_busy && sweep_q != TOP)
      |=> (cnt_q == (($past(cnt_q) >= TOP) ? ONE : $past(cnt_q) + ONE)))
      else $error("count did not step"); // R3

   AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PA_HOLD && bus_busy) |=> $stable(cnt_q)) else $error("count moved while held"); // R4

   AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PA_POLL && !bus_busy && sweep_q == TOP) |=> (cnt_q == '0))
      else $error("sweep did not end"); // R8
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
   parameter int N_DEV = 6,
   parameter int CNT_W = $clog2(N_DEV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rr_mode,
   input  logic [N_DEV-1:0] dev_req,
   output logic             bus_req,
   output logic             bus_busy,
   output logic [N_DEV-1:0] dev_busy,
   output logic [CNT_W-1:0] poll_cnt,
   output logic [CNT_W-1:0] owner_id
);
   initial begin
      if (N_DEV < 2)                 $error("poll_arbiter: N_DEV must be at least 2");
      if ((1 << CNT_W) < N_DEV + 1)  $error("poll_arbiter: CNT_W too narrow for N_DEV");
   end

   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] start_w;
   logic [CNT_W-1:0] last_w;
   logic [CNT_W-1:0] owner_q;

   generate
      for (genvar i = 0; i < N_DEV; i++) begin : g_dev
         poll_dev_match #(.CNT_W(CNT_W), .ADDR(i + 1)) u_match (
            .req  (dev_req[i]),
            .cnt  (cnt_w),
            .busy (dev_busy[i])
         );
      end
   endgenerate

   assign bus_req  = |dev_req;
   assign bus_busy = |dev_busy;

   poll_restart #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_restart (
      .rr_mode    (rr_mode),
      .last_owner (last_w),
      .start_cnt  (start_w)
   );

   poll_sequencer #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_req    (bus_req),
      .bus_busy   (bus_busy),
      .start_cnt  (start_w),
      .cnt        (cnt_w),
      .last_owner (last_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        owner_q <= '0;
      else if (bus_busy) owner_q <= cnt_w;
      else               owner_q <= '0;
   end

   assign poll_cnt = cnt_w;
   assign owner_id = owner_q;

   AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_busy)) else $error("more than one device busy"); // R4

   AST_OWNER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      bus_busy |=> (owner_id == $past(poll_cnt))) else $error("owner mismatch"); // R5

   AST_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |=> (owner_id == '0)) else $error("owner not cleared"); // R9
endmodule

// File: tb/tb_poll_arbiter.sv
`timescale 1ns/1ps
module tb_poll_arbiter;
   localparam int N = 6;
   localparam int W = 3;
   localparam int NV = 8;

   // Rows: mode, request mask, expected owner, expected latency.
   // Rows run in order, so round-robin rows depend on the owners before them.
   localparam int V_MODE [NV] = '{0, 0, 1, 1, 1, 0, 1, 1};
   localparam int V_MASK [NV] = '{6'b000100, 6'b010010, 6'b010010, 6'b100001,
                                  6'b100001, 6'b100000, 6'b001000, 6'b000100};
   localparam int V_OWN  [NV] = '{3, 2, 5, 6, 1, 6, 4, 3};
   localparam int V_LAT  [NV] = '{4, 3, 4, 2, 2, 7, 5, 6};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rr_mode = 1'b0;
   logic [N-1:0] dev_req = '0;
   logic         bus_req, bus_busy;
   logic [N-1:0] dev_busy;
   logic [W-1:0] poll_cnt, owner_id;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   poll_arbiter #(.N_DEV(N)) dut (
      .clk(clk), .rst_n(rst_n), .rr_mode(rr_mode), .dev_req(dev_req),
      .bus_req(bus_req), .bus_busy(bus_busy), .dev_busy(dev_busy),
      .poll_cnt(poll_cnt), .owner_id(owner_id)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int lat;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 poll_cnt", poll_cnt, 0);
      chk("R10 owner_id", owner_id, 0);
      chk("R10 bus_busy", bus_busy, 0);
      rst_n = 1'b1;

      // R2: count 0 matches nobody; R1: request OR
      dev_req = '1;
      #0.1;
      chk("R2 busy at count 0", bus_busy, 0);
      chk("R1 bus_req all", bus_req, 1);
      dev_req = '0;
      #0.1;
      chk("R1 bus_req none", bus_req, 0);

      // Table walk: R6 priority, R7 round-robin, R5 owner
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         rr_mode = V_MODE[i][0];
         dev_req = V_MASK[i][N-1:0];
         lat = 0;
         do begin
            @(negedge clk);
            lat++;
         end while (owner_id == 0 && lat < 20);
         if (V_MODE[i] == 0) begin
            chk("R6 owner", owner_id, V_OWN[i]);
            chk("R6 latency", lat, V_LAT[i]);
         end else begin
            chk("R7 owner", owner_id, V_OWN[i]);
            chk("R7 latency", lat, V_LAT[i]);
         end
         chk("R4 frozen count", poll_cnt, V_OWN[i]);
         chk("R4 busy bit", dev_busy, 1 << (V_OWN[i] - 1));
         chk("R5 owner equals count", owner_id, poll_cnt);
         dev_req = '0;
         @(negedge clk);
         chk("R9 owner cleared", owner_id, 0);
         chk("R9 count cleared", poll_cnt, 0);
      end

      // R4: hold is not disturbed by a higher-priority request
      @(negedge clk);
      rr_mode = 1'b0;
      dev_req = 6'b000010;
      repeat (3) @(negedge clk);
      chk("R4 first owner", owner_id, 2);
      dev_req = 6'b000011;
      repeat (3) @(negedge clk);
      chk("R4 owner kept", owner_id, 2);
      chk("R4 count kept", poll_cnt, 2);
      chk("R1 bus_req two", bus_req, 1);
      // R6: after release, priority mode restarts at 1
      dev_req = 6'b000001;
      repeat (3) @(negedge clk);
      chk("R6 restart at 1", owner_id, 1);
      dev_req = '0;
      @(negedge clk);
      chk("R9 release", owner_id, 0);

      // R8: requester withdraws, so a full sweep ends without a match
      @(negedge clk);
      dev_req = 6'b100000;
      @(negedge clk);
      chk("R2 round starts", poll_cnt, 1);
      dev_req = '0;
      for (int k = 2; k <= N; k++) begin
         @(negedge clk);
         chk("R3 count step", poll_cnt, k);
      end
      @(negedge clk);
      chk("R8 sweep end count", poll_cnt, 0);
      chk("R8 no owner", owner_id, 0);
      @(negedge clk);
      chk("R2 stays idle", poll_cnt, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule